// File: doc/BRIEF.md
# Serial Register Write-Protect Controller

This block is the target side of a serial register port on a flash-style device. It listens to a mode-0 serial bus and recognises two commands. A short arming command sets a write-enable latch. A register-write command carries one byte for the status register and one byte for the configuration register. The block owns both registers. It decides whether a register write lands by looking at three things together: the latch, a sticky write-disable bit kept in the status register, and a live write-protect pin.

The serial inputs are brought into the block's own clock domain through synchronisers, and all decoding is done on that clock. A command is committed only when chip select returns high. At that moment the number of serial clock rises must be exactly right for the command. The three block-protect bits are exported so the memory array can mark its read-only region. The serial data output is never driven by these commands.

Top module: `spi_wp_regs`

## Requirements
- R1: A frame of exactly 8 serial clocks carrying opcode 0x06, sent MSB first, sets the write-enable latch. The latch is visible as status bit 1.
- R2: A frame of exactly 24 clocks carrying opcode 0x01, then a status byte, then a configuration byte (each MSB first), is accepted when the latch is set and status bit 7 (write-disable) is 0, at any level of wp_n. On acceptance, status bits 7:2 take the written value, the configuration register takes its whole byte, and status bit 0 always reads 0.
- R3: A register-write frame arriving while the latch is clear changes neither register.
- R4: With write-disable at 1 and wp_n high, a register write with the latch set is accepted.
- R5: With write-disable at 1 and wp_n low, a register write is rejected even with the latch set, and both registers keep their values.
- R6: Hardware locking works in both orders: write-disable set while the pin is already low, or the pin driven low after write-disable is set. Driving wp_n high is the only way to release the lock.
- R7: The write-enable latch is cleared at the end of every complete register-write frame, whether it was accepted or rejected.
- R8: A frame whose chip select rises after any count other than 8 or 24, or that carries any other opcode, changes neither the registers nor the latch.
- R9: spi_so_oe stays 0 at all times, so the serial output remains high-impedance.
- R10: After reset both registers and the latch read 0.
- R11: blk_prot always equals status bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| spi_so | output | 1 | Serial data out (held 0) |
| spi_so_oe | output | 1 | Output enable for spi_so (held 0) |
| status_q | output | 8 | Status register contents |
| config_q | output | 8 | Configuration register contents |
| blk_prot | output | 3 | Block-protect field |

## Verification
A change on chip select reaches the registers on the fourth rising clk edge after it. It passes through two synchroniser stages, then the edge detector and event register, then the register update. The latch and status bit 1 follow on that same edge. The bench drives every input on the falling clk edge and holds each serial clock level for four clk periods. After raising chip select it waits ten clk periods before comparing the outputs with its model, which leaves a margin of six cycles. The output-enable check is taken in the middle of each frame.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_REGWR = 8'h01;
  localparam int LOCK_BIT = 7;
  localparam int ARM_BIT  = 1;
  localparam int PROT_LSB = 2;
  localparam int PROT_W   = 3;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ARM   = 2'd1,
    EV_REGWR = 2'd2
  } frame_ev_e;
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wpc_frame_rx.sv
module wpc_frame_rx
  import wpc_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 sck_s,
  input  logic                 si_s,
  output frame_ev_e            ev,
  output logic [DATA_BITS-1:0] payload
);
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                  sck_d_q, cs_d_q;
  logic [CNT_W-1:0]      cnt_q, cnt_nxt;
  logic [FRAME_BITS-1:0] sh_q, sh_nxt;
  frame_ev_e             ev_q, ev_nxt;
  logic                  sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_d_q & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_d_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (cs_n_s)                            cnt_nxt = '0;
    else if (sck_rise && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
  end

  always_comb begin
    sh_nxt = sh_q;
    if (sck_rise && cnt_q < CNT_W'(FRAME_BITS))
      sh_nxt = {sh_q[FRAME_BITS-2:0], si_s};
  end

  always_comb begin
    ev_nxt = EV_NONE;
    if (cs_rise) begin
      if (cnt_q == CNT_W'(CMD_BITS) && sh_q[CMD_BITS-1:0] == OP_ARM)
        ev_nxt = EV_ARM;
      else if (cnt_q == CNT_W'(FRAME_BITS) && sh_q[FRAME_BITS-1 -: CMD_BITS] == OP_REGWR)
        ev_nxt = EV_REGWR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      ev_q    <= EV_NONE;
    end else begin
      sck_d_q <= sck_s;
      cs_d_q  <= cs_n_s;
      cnt_q   <= cnt_nxt;
      sh_q    <= sh_nxt;
      ev_q    <= ev_nxt;
    end
  end

  assign ev      = ev_q;
  assign payload = sh_q[DATA_BITS-1:0];

  // R8: the bit counter is cleared while chip select is high
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0));
  // R8: a command event only follows a chip-select rise
  p_ev_on_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q != EV_NONE) |-> $past(cs_rise));
endmodule

// File: rtl/wpc_reg_bank.sv
module wpc_reg_bank
  import wpc_pkg::*;
#(
  parameter int REG_W = 8,
  parameter logic [REG_W-1:0] STAT_WMASK = 8'hFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  frame_ev_e          ev,
  input  logic [2*REG_W-1:0] wr_data,
  input  logic               wp_n_s,
  output logic [REG_W-1:0]   status_q,
  output logic [REG_W-1:0]   config_q,
  output logic [PROT_W-1:0]  blk_prot
);
  logic             arm_q, arm_nxt;
  logic [REG_W-1:0] sreg_q, sreg_nxt;
  logic [REG_W-1:0] creg_q, creg_nxt;
  logic             hw_lock, wr_ok, sreg_en;

  assign hw_lock = sreg_q[LOCK_BIT] & ~wp_n_s;
  assign wr_ok   = (ev == EV_REGWR) & arm_q & ~hw_lock;
  assign sreg_en = wr_ok;

  always_comb begin
    arm_nxt = arm_q;
    if (ev == EV_ARM)        arm_nxt = 1'b1;
    else if (ev == EV_REGWR) arm_nxt = 1'b0;
  end

  always_comb begin
    sreg_nxt = sreg_q;
    creg_nxt = creg_q;
    if (sreg_en) begin
      sreg_nxt = wr_data[2*REG_W-1:REG_W] & STAT_WMASK;
      creg_nxt = wr_data[REG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      sreg_q <= '0;
      creg_q <= '0;
    end else begin
      arm_q  <= arm_nxt;
      sreg_q <= sreg_nxt;
      creg_q <= creg_nxt;
    end
  end

  always_comb begin
    status_q = sreg_q;
    status_q[ARM_BIT] = arm_q;
  end
  assign config_q = creg_q;
  assign blk_prot = sreg_q[PROT_LSB +: PROT_W];

  p_arm_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_ARM) |=> arm_q);
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_REGWR && arm_q && !sreg_q[LOCK_BIT]) |=> (creg_q == $past(wr_data[REG_W-1:0])));
  p_no_arm_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |=> ($stable(creg_q) && $stable(sreg_q)));
  p_pin_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_REGWR && sreg_q[LOCK_BIT] && !wp_n_s) |=> ($stable(creg_q) && $stable(sreg_q)));
  p_arm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_REGWR) |=> !arm_q);
endmodule

// File: rtl/spi_wp_regs.sv
module spi_wp_regs
  import wpc_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int REG_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_si,
  input  logic             wp_n,
  output logic             spi_so,
  output logic             spi_so_oe,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] config_q,
  output logic [2:0]       blk_prot
);
  localparam int DATA_BITS = 2 * REG_W;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [3:0] pins_s;
  wpc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({wp_n, spi_si, spi_sck, spi_cs_n}),
    .q     (pins_s)
  );

  frame_ev_e            ev;
  logic [DATA_BITS-1:0] payload;

  wpc_frame_rx #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cs_n_s  (pins_s[0]),
    .sck_s   (pins_s[1]),
    .si_s    (pins_s[2]),
    .ev      (ev),
    .payload (payload)
  );

  logic [PROT_W-1:0] prot;
  wpc_reg_bank #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ev       (ev),
    .wr_data  (payload),
    .wp_n_s   (pins_s[3]),
    .status_q (status_q),
    .config_q (config_q),
    .blk_prot (prot)
  );

  assign blk_prot  = prot;
  assign spi_so    = 1'b0;
  assign spi_so_oe = 1'b0;

  // R11: exported protect field tracks status bits 4:2
  p_prot_field_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    blk_prot == status_q[4:2]);
endmodule

// File: tb/spi_wp_regs_tb_top.sv
module spi_wp_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp = 1'b1;
  logic so, so_oe;
  logic [7:0] st, cf;
  logic [2:0] bp;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_s = 8'h00, m_c = 8'h00;
  logic       m_arm = 1'b0;

  always #10 clk = ~clk;

  spi_wp_regs dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .wp_n(wp), .spi_so(so), .spi_so_oe(so_oe),
    .status_q(st), .config_q(cf), .blk_prot(bp)
  );

  function automatic logic [7:0] exp_status();
    return (m_s & 8'hFC) | {6'b0, m_arm, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_frame(input logic [31:0] w, input int n);
    if (n == 8 && w[7:0] == 8'h06) m_arm = 1'b1;
    else if (n == 24 && w[23:16] == 8'h01) begin
      if (m_arm && !(m_s[7] && !wp)) begin
        m_s = w[15:8] & 8'hFC;
        m_c = w[7:0];
      end
      m_arm = 1'b0;
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " status"}, st, exp_status());
    chk({req, " config"}, cf, m_c);
    chk("R11 blk_prot", {5'b0, bp}, {5'b0, m_s[4:2]});
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      si = w[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      if (i == n / 2) chk("R9 so_oe", {7'b0, so_oe}, 8'h00);
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    model_frame(w, n);
  endtask

  task automatic arm();
    frame(32'h06, 8);
  endtask

  task automatic regwr(input logic [7:0] s, input logic [7:0] c);
    frame({8'h00, 8'h01, s, c}, 24);
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd51237));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 reset status", st, 8'h00);
    chk("R10 reset config", cf, 8'h00);
    chk("R9 reset so_oe", {7'b0, so_oe}, 8'h00);

    regwr(8'hA4, 8'h3C);                 // no latch
    chk("R3 status", st, 8'h00);
    chk("R3 config", cf, 8'h00);

    arm();
    chk("R1 latch", st, 8'h02);

    frame({8'h00, 8'h01, 8'h1C, 8'h5A} >> 1, 23);   // aborted
    chk("R8 abort keeps latch", st, 8'h02);
    chk("R8 abort config", cf, 8'h00);

    wp = 1'b0;
    regwr(8'h1F, 8'h5A);                 // lock bit 0, pin low
    chk("R2 status", st, 8'h1C);
    chk("R2 config", cf, 8'h5A);
    chk("R11 bp", {5'b0, bp}, 8'h07);
    chk("R7 latch cleared", {7'b0, st[1]}, 8'h00);

    wp = 1'b1;
    arm();
    regwr(8'h88, 8'hC3);
    chk("R4 status", st, 8'h88);
    chk("R4 config", cf, 8'hC3);

    wp = 1'b0;                           // pin after lock bit
    arm();
    regwr(8'h00, 8'h00);
    chk("R5 status", st, 8'h88);
    chk("R5 config", cf, 8'hC3);
    chk("R7 latch cleared on reject", {7'b0, st[1]}, 8'h00);

    wp = 1'b1;                           // release
    arm();
    regwr(8'h00, 8'h11);
    chk("R6 release", cf, 8'h11);

    wp = 1'b0;                           // lock bit after pin
    arm();
    regwr(8'h80, 8'h22);
    chk("R6 set while low", st, 8'h80);
    arm();
    regwr(8'h00, 8'h33);
    chk("R6 locked", cf, 8'h22);
    check_all("R6");

    frame(32'h07, 8);                    // unknown opcode
    check_all("R8 opcode");

    for (int it = 0; it < 150; it++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if ($urandom_range(0, 3) == 0) wp = ~wp;
      case (r)
        0, 1, 2: arm();
        3, 4, 5: regwr(8'($urandom), 8'($urandom));
        6: frame({8'h00, 8'($urandom), 16'($urandom)}, 24);
        7: begin
          int n;
          n = int'($urandom_range(0, 31));
          if (n == 8 || n == 24) n = n + 1;
          frame($urandom, n);
        end
        default: frame({24'h0, 8'($urandom)}, 8);
      endcase
      check_all("R2 R5 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule